// File: doc/BRIEF.md
# Receive DMA Channel with Descriptor Ring

This block is one receive channel of a DMA engine. It takes an incoming byte stream, split into packets by an end marker, and stores each packet in a buffer in system memory. A circular list of buffer descriptors in memory says where each buffer is. Software gives a descriptor to the engine by setting its ownership bit. The engine fetches that descriptor and fills its buffer. It then writes the descriptor back with the received length and framing flags, and with ownership cleared so that software may take the buffer.

Software sets up the channel through a small register port. Register 0 holds the run control: enable and two halt requests. Register 1 holds the ring start address and register 2 the burst length. A separate channel reset input returns the engine to the first descriptor of the ring. The engine has one memory port for descriptor reads, data writes and descriptor writeback. It issues one request at a time.

Top module: `rxdma_channel`

## Requirements
- R1: A descriptor is two 32-bit words. The word at the descriptor address holds the buffer length in bits 31:16 and the status in bits 15:0. The word at descriptor address + 4 holds the buffer address. The engine reads both words before it accepts any byte into that buffer.
- R2: Status bit 15 is ownership, and 1 means the engine owns the descriptor. If a fetched descriptor has bit 15 = 0, the engine clears enable and holds in_ready low. When software sets enable again, the engine fetches that same descriptor again.
- R3: Byte k of a packet is written to buffer address + k. The write is a single-lane access: mem_be has the one bit given by the byte address bits 1:0, and the byte is repeated on all four lanes of mem_wdata.
- R4: Writeback is one full-word write (mem_be = 4'hF) to the descriptor address. It carries the stored byte count in bits 31:16. Bit 15 is written 0. Bit 14 (end of packet) and bit 13 (start of packet) are written 1. Bit 12 (wrap) keeps the value it had in the fetched descriptor. The writeback is issued only after the memory port has accepted the last data byte.
- R5: After a descriptor whose wrap bit 12 is set, the next descriptor fetched is at the ring start address. Otherwise it is at the descriptor address + 8.
- R6: Bytes past the buffer length are consumed from the stream but not written to memory. In that case the written-back length equals the buffer length and status bit 0 (overflow) is 1.
- R7: If in_err is high on any accepted byte of a packet, status bit 2 of that descriptor's writeback is 1. Otherwise bit 2 is 0.
- R8: Register 0 holds enable in bit 0, the packet-halt request in bit 1 and the burst-halt request in bit 2. Register 1 holds the ring start address and register 2 the burst length. Writing 1 to bit 0 sets enable, and writing 0 to bit 0 has no effect. Enable reads 1 until the engine itself stops.
- R9: A packet-halt request lets the packet in progress finish and be written back. The engine then stops before it fetches another descriptor, and register 0 reads 0.
- R10: Burst length must be at least 1. A burst-halt request stops the engine once the number of bytes stored since the descriptor was fetched reaches a multiple of the burst length. At that point register 0 reads 0 and in_ready stays low. Setting enable resumes filling the same buffer at the next offset.
- R11: A ch_rst pulse clears register 0. The next fetch after enable is then at the ring start address.
- R12: After rst_n, register 0 reads 0, register 2 reads 16, and both mem_req and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ch_rst | input | 1 | Channel reset pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted |
| in_data | input | 8 | Stream byte |
| in_eop | input | 1 | Last byte of packet |
| in_err | input | 1 | Receive error on this byte |

## Verification
The corner cases the bench targets, and the wrong behaviour each one exposes:

- **Packet longer than its buffer.** The bench places a sentinel byte just past the buffer. A design that ignores the limit overwrites the sentinel. A design that stops consuming bytes hangs the stream.
- **Ring wrap onto a descriptor software still holds.** A design that ignores the wrap bit reads past the end of the ring. A design that ignores ownership accepts bytes into a buffer software still holds.
- **A halt request issued in the middle of a packet.** A packet halt that stops too early leaves the descriptor unwritten. A burst halt that stops at the wrong point stores the wrong number of bytes before it pauses.
- **Resume after a burst halt.** A design that loses its offset on resume writes the remaining bytes to the wrong addresses.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;

    // status field bit positions (fixed by the descriptor format)
    localparam int ST_OWN  = 15;
    localparam int ST_EOP  = 14;
    localparam int ST_SOP  = 13;
    localparam int ST_WRAP = 12;
    localparam int ST_RERR = 2;
    localparam int ST_OVF  = 0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD0,
        S_RD0W,
        S_RD1,
        S_RD1W,
        S_DATA,
        S_PAUSE,
        S_WB
    } eng_state_e;

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] desc_ptr;
        logic [ADDR_W-1:0] buf_addr;
        logic [LEN_W-1:0]  buf_len;
        logic [LEN_W-1:0]  count;
        logic [LEN_W-1:0]  bcnt;
        logic              wrap;
        logic              started;
        logic              ovf;
        logic              err;
    } eng_t;

    typedef struct packed {
        logic              enable;
        logic              pkt_halt;
        logic              brst_halt;
        logic [ADDR_W-1:0] ring;
        logic [LEN_W-1:0]  burst;
    } cfg_t;

endpackage

// File: rtl/rxdma_cfg_regs.sv
module rxdma_cfg_regs
    import rxdma_pkg::*;
#(
    parameter logic [LEN_W-1:0] BURST_RESET = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              eng_stop,
    output logic              enable,
    output logic              pkt_halt,
    output logic              brst_halt,
    output logic [ADDR_W-1:0] ring_start,
    output logic [LEN_W-1:0]  burst_len
);

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (eng_stop) begin
            c_d.enable    = 1'b0;
            c_d.pkt_halt  = 1'b0;
            c_d.brst_halt = 1'b0;
        end
        if (cfg_we) begin
            unique case (cfg_addr)
                2'd0: begin
                    c_d.enable    = c_d.enable | cfg_wdata[0];
                    c_d.pkt_halt  = c_d.pkt_halt | cfg_wdata[1];
                    c_d.brst_halt = c_d.brst_halt | cfg_wdata[2];
                end
                2'd1:    c_d.ring  = cfg_wdata[ADDR_W-1:0];
                2'd2:    c_d.burst = cfg_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
        if (ch_rst) begin
            c_d.enable    = 1'b0;
            c_d.pkt_halt  = 1'b0;
            c_d.brst_halt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{enable: 1'b0, pkt_halt: 1'b0, brst_halt: 1'b0,
                     ring: '0, burst: BURST_RESET};
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            2'd0:    cfg_rdata = {29'd0, c_q.brst_halt, c_q.pkt_halt, c_q.enable};
            2'd1:    cfg_rdata = c_q.ring;
            2'd2:    cfg_rdata = {{(32-LEN_W){1'b0}}, c_q.burst};
            default: cfg_rdata = '0;
        endcase
    end

    assign enable     = c_q.enable;
    assign pkt_halt   = c_q.pkt_halt;
    assign brst_halt  = c_q.brst_halt;
    assign ring_start = c_q.ring;
    assign burst_len  = c_q.burst;

    // enable only drops because the engine stopped or the channel was reset
    assert_enable_falls_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.enable) |-> ($past(eng_stop) || $past(ch_rst)));

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
    import rxdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_rst,
    input  logic              enable,
    input  logic              pkt_halt,
    input  logic              brst_halt,
    input  logic [ADDR_W-1:0] ring_start,
    input  logic [LEN_W-1:0]  burst_len,
    output logic              stop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_eop,
    input  logic              in_err
);

    eng_t s_d, s_q;

    logic              halt_any;
    logic              accept;
    logic              burst_end;
    logic [ADDR_W-1:0] data_addr;
    logic [15:0]       wb_status;

    assign halt_any  = pkt_halt | brst_halt;
    assign data_addr = s_q.buf_addr + ADDR_W'(s_q.count);

    always_comb begin
        wb_status          = '0;
        wb_status[ST_EOP]  = 1'b1;
        wb_status[ST_SOP]  = 1'b1;
        wb_status[ST_WRAP] = s_q.wrap;
        wb_status[ST_RERR] = s_q.err;
        wb_status[ST_OVF]  = s_q.ovf;
    end

    always_comb begin
        s_d       = s_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        in_ready  = 1'b0;
        stop      = 1'b0;
        accept    = 1'b0;
        burst_end = 1'b0;

        unique case (s_q.st)
            S_IDLE, S_PAUSE: begin
                if (enable) begin
                    if (halt_any) stop = 1'b1;
                    else          s_d.st = (s_q.st == S_IDLE) ? S_RD0 : S_DATA;
                end
            end
            S_RD0: begin
                if (halt_any) begin
                    stop   = 1'b1;
                    s_d.st = S_IDLE;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = s_q.desc_ptr;
                    if (mem_gnt) s_d.st = S_RD0W;
                end
            end
            S_RD0W: begin
                if (mem_rvalid) begin
                    s_d.buf_len = mem_rdata[31:16];
                    s_d.wrap    = mem_rdata[ST_WRAP];
                    if (mem_rdata[ST_OWN]) begin
                        s_d.st = S_RD1;
                    end else begin
                        stop   = 1'b1;
                        s_d.st = S_IDLE;
                    end
                end
            end
            S_RD1: begin
                mem_req  = 1'b1;
                mem_addr = s_q.desc_ptr + ADDR_W'(4);
                if (mem_gnt) s_d.st = S_RD1W;
            end
            S_RD1W: begin
                if (mem_rvalid) begin
                    s_d.buf_addr = mem_rdata;
                    s_d.count    = '0;
                    s_d.bcnt     = '0;
                    s_d.started  = 1'b0;
                    s_d.ovf      = 1'b0;
                    s_d.err      = 1'b0;
                    s_d.st       = S_DATA;
                end
            end
            S_DATA: begin
                if (!s_q.started && halt_any) begin
                    stop   = 1'b1;
                    s_d.st = S_IDLE;
                end else if (in_valid) begin
                    if (s_q.count < s_q.buf_len) begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = data_addr;
                        mem_be    = 4'b0001 << data_addr[1:0];
                        mem_wdata = {4{in_data}};
                        if (mem_gnt) begin
                            accept    = 1'b1;
                            s_d.count = s_q.count + 1'b1;
                            if (s_q.bcnt + 1'b1 == burst_len) begin
                                s_d.bcnt  = '0;
                                burst_end = 1'b1;
                            end else begin
                                s_d.bcnt = s_q.bcnt + 1'b1;
                            end
                        end
                    end else begin
                        accept  = 1'b1;
                        s_d.ovf = 1'b1;
                    end
                    in_ready = accept;
                    if (accept) begin
                        s_d.started = 1'b1;
                        s_d.err     = s_q.err | in_err;
                        if (in_eop) begin
                            s_d.st = S_WB;
                        end else if (burst_end && brst_halt) begin
                            stop   = 1'b1;
                            s_d.st = S_PAUSE;
                        end
                    end
                end
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = s_q.desc_ptr;
                mem_be    = 4'hF;
                mem_wdata = {s_q.count, wb_status};
                if (mem_gnt) begin
                    s_d.desc_ptr = s_q.wrap ? ring_start : s_q.desc_ptr + ADDR_W'(8);
                    s_d.st       = S_RD0;
                end
            end
            default: s_d.st = S_IDLE;
        endcase

        if (ch_rst) begin
            s_d          = s_q;
            s_d.st       = S_IDLE;
            s_d.desc_ptr = ring_start;
            s_d.count    = '0;
            s_d.bcnt     = '0;
            s_d.started  = 1'b0;
            s_d.ovf      = 1'b0;
            s_d.err      = 1'b0;
            mem_req      = 1'b0;
            in_ready     = 1'b0;
            stop         = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, desc_ptr: '0, buf_addr: '0, buf_len: '0,
                     count: '0, bcnt: '0, wrap: 1'b0, started: 1'b0,
                     ovf: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // data byte writes stay inside the buffer of the current descriptor
    assert_byte_in_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |->
        ((mem_addr - s_q.buf_addr) < ADDR_W'(s_q.buf_len)));

    // a data byte write touches exactly one lane
    assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> $onehot(mem_be));

    // a wrapping descriptor sends the next fetch back to the ring start
    assert_wrap_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_WB && mem_gnt && s_q.wrap && !ch_rst) |=>
        (s_q.desc_ptr == $past(ring_start)));

    // the stream is never accepted while the channel is disabled
    assert_ready_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> enable);

    // a stop only happens on a running channel
    assert_stop_while_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> enable);

endmodule

// File: rtl/rxdma_channel.sv
module rxdma_channel
    import rxdma_pkg::*;
#(
    parameter int BURST_RESET = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ch_rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_eop,
    input  logic        in_err
);

    logic              eng_stop;
    logic              enable;
    logic              pkt_halt;
    logic              brst_halt;
    logic [ADDR_W-1:0] ring_start;
    logic [LEN_W-1:0]  burst_len;

    rxdma_cfg_regs #(
        .BURST_RESET(LEN_W'(BURST_RESET))
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_rst    (ch_rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .eng_stop  (eng_stop),
        .enable    (enable),
        .pkt_halt  (pkt_halt),
        .brst_halt (brst_halt),
        .ring_start(ring_start),
        .burst_len (burst_len)
    );

    rxdma_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_rst    (ch_rst),
        .enable    (enable),
        .pkt_halt  (pkt_halt),
        .brst_halt (brst_halt),
        .ring_start(ring_start),
        .burst_len (burst_len),
        .stop      (eng_stop),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_eop    (in_eop),
        .in_err    (in_err)
    );

endmodule

// File: tb/rxdma_channel_tb.sv
module rxdma_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_rst = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_gnt;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_eop = 1'b0;
    logic        in_err = 1'b0;

    always #5 clk = ~clk;

    rxdma_channel u_dut (.*);

    // memory model: 256 words, always grants, read data one cycle later
    logic [31:0] mem [0:255];
    logic [31:0] last_rd;
    logic        tb_we = 1'b0;
    logic [31:0] tb_waddr = '0;
    logic [31:0] tb_wdata = '0;

    assign mem_gnt = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            last_rd    <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (tb_we) mem[tb_waddr[9:2]] <= tb_wdata;
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                end else begin
                    mem_rdata  <= mem[mem_addr[9:2]];
                    mem_rvalid <= 1'b1;
                    last_rd    <= mem_addr;
                end
            end
        end
    end

    int checks = 0;
    int fails = 0;
    int acc_cnt = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        return mem[a[9:2]][8*a[1:0] +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] cfg_rd(input logic [1:0] a);
        cfg_addr = a;
        return cfg_rdata;
    endfunction

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic pulse_rst();
        ch_rst = 1'b1;
        @(negedge clk);
        ch_rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pkt(input int n, input logic [7:0] base, input bit err_last);
        for (int i = 0; i < n; i++) begin
            int t;
            in_valid = 1'b1;
            in_data  = base + 8'(i);
            in_eop   = (i == n - 1);
            in_err   = err_last && (i == n - 1);
            t = 0;
            #1;
            while (!in_ready && t < 300) begin
                @(negedge clk);
                #1;
                t++;
            end
            if (t == 300) begin
                fails++;
                $display("FAIL stream stall actual=%0d expected=%0d", i, n);
            end
            @(posedge clk);
            acc_cnt++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_eop   = 1'b0;
        in_err   = 1'b0;
    endtask

    logic [31:0] rv;

    task automatic t_reset();
        cfg_read(2'd0, rv); chk("R12 ctrl", rv, 32'd0);
        cfg_read(2'd2, rv); chk("R12 burst", rv, 32'd16);
        chk("R12 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R12 in_ready", {31'd0, in_ready}, 32'd0);
    endtask

    task automatic t_basic();
        poke(32'h100, {16'd16, 16'h8000}); poke(32'h104, 32'h200);
        poke(32'h108, {16'd16, 16'h8000}); poke(32'h10C, 32'h240);
        poke(32'h110, {16'd8,  16'h9000}); poke(32'h114, 32'h280);
        poke(32'h288, 32'h5A5A5A5A);
        cfg_wr(2'd1, 32'h100);
        cfg_wr(2'd2, 32'd64);
        pulse_rst();
        cfg_wr(2'd0, 32'h1);
        idle(10);
        cfg_read(2'd1, rv); chk("R8 ring readback", rv, 32'h100);
        cfg_read(2'd2, rv); chk("R8 burst readback", rv, 32'd64);
        cfg_wr(2'd0, 32'h0);
        cfg_read(2'd0, rv); chk("R8 enable write of 0 ignored", rv, 32'h1);
        chk("R1 buffer address fetched", last_rd, 32'h104);
        send_pkt(5, 8'hA0, 1'b0);
        idle(4);
        chk("R4 writeback desc0", mem[32'h100 >> 2], {16'd5, 16'h6000});
        for (int i = 0; i < 5; i++)
            chk("R3 byte placement", {24'd0, rd_byte(32'h200 + 32'(i))}, 32'hA0 + 32'(i));
    endtask

    task automatic t_err();
        send_pkt(3, 8'h10, 1'b1);
        idle(4);
        chk("R7 error flag in writeback", mem[32'h108 >> 2], {16'd3, 16'h6004});
        chk("R5 sequential next descriptor", last_rd, 32'h114);
    endtask

    task automatic t_ovf_wrap();
        send_pkt(11, 8'h30, 1'b0);
        idle(10);
        chk("R6 overflow writeback", mem[32'h110 >> 2], {16'd8, 16'h7001});
        chk("R6 sentinel untouched", {24'd0, rd_byte(32'h288)}, 32'h5A);
        chk("R6 last stored byte", {24'd0, rd_byte(32'h287)}, 32'h37);
        chk("R5 wrap fetch at ring start", last_rd, 32'h100);
        cfg_read(2'd0, rv); chk("R2 unowned clears enable", rv, 32'h0);
        in_valid = 1'b1; in_data = 8'hEE;
        #1;
        chk("R2 stream held off", {31'd0, in_ready}, 32'd0);
        idle(3);
        chk("R2 stream still held off", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b0;
        chk("R2 descriptor untouched", mem[32'h100 >> 2], {16'd5, 16'h6000});
        poke(32'h100, {16'd16, 16'h8000});
        poke(32'h108, {16'd16, 16'h8000});
        cfg_wr(2'd0, 32'h1);
        idle(8);
        send_pkt(2, 8'hB0, 1'b0);
        idle(10);
        chk("R2 refetch after re-enable", mem[32'h100 >> 2], {16'd2, 16'h6000});
        chk("R2 resumed data", {24'd0, rd_byte(32'h201)}, 32'hB1);
    endtask

    task automatic t_pkt_halt();
        fork
            send_pkt(4, 8'h50, 1'b0);
            begin
                idle(2);
                cfg_wr(2'd0, 32'h2);
            end
        join
        idle(10);
        chk("R9 packet finished", mem[32'h108 >> 2], {16'd4, 16'h6000});
        cfg_read(2'd0, rv); chk("R9 control cleared", rv, 32'h0);
        chk("R9 no further fetch", last_rd, 32'h10C);
    endtask

    task automatic t_burst_halt();
        poke(32'h100, {16'd16, 16'h8000});
        cfg_wr(2'd2, 32'd4);
        pulse_rst();
        cfg_wr(2'd0, 32'h1);
        idle(10);
        acc_cnt = 0;
        fork
            send_pkt(10, 8'hC0, 1'b0);
            begin
                idle(2);
                cfg_wr(2'd0, 32'h4);
                idle(20);
                chk("R10 stored bytes at stop", 32'(acc_cnt), 32'd4);
                cfg_read(2'd0, rv); chk("R10 control cleared", rv, 32'h0);
                chk("R10 stream held", {31'd0, in_ready}, 32'd0);
                chk("R10 no writeback yet", mem[32'h100 >> 2], {16'd16, 16'h8000});
                cfg_wr(2'd0, 32'h1);
            end
        join
        idle(6);
        chk("R10 writeback after resume", mem[32'h100 >> 2], {16'd10, 16'h6000});
        for (int i = 0; i < 10; i++)
            chk("R10 resumed offsets", {24'd0, rd_byte(32'h200 + 32'(i))}, 32'hC0 + 32'(i));
    endtask

    task automatic t_ch_rst();
        poke(32'h100, {16'd16, 16'h8000});
        pulse_rst();
        cfg_read(2'd0, rv); chk("R11 control after reset", rv, 32'h0);
        cfg_wr(2'd0, 32'h1);
        idle(10);
        chk("R11 fetch from ring start", last_rd, 32'h104);
        cfg_read(2'd0, rv); chk("R11 running on owned descriptor", rv, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_basic();
        t_err();
        t_ovf_wrap();
        t_pkt_halt();
        t_burst_halt();
        t_ch_rst();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule